// File: doc/BRIEF.md
# Ring-Count Answering Controller

A synchronous controller for a telephone answering machine. It waits in an idle listening state and counts incoming ring pulses. It goes off hook after one ring when a stored message is waiting, and after four rings when none is. The early pickup tells a remote caller that messages are waiting. Once off hook it plays the outgoing announcement until the announcement source reports its end. It then records the caller's message until recording ends or a record timeout expires, and then hangs up.

If a valid remote-access tone is detected during the announcement, the controller abandons the announcement and plays back the stored messages instead. When playback reports its end, it hangs up. The ring input comes from outside the clock domain, so it is passed through a two-flop synchronizer and counted on its rising edge. The tone and end-of-phase inputs are single-cycle synchronous pulses. The outputs are level enables for the hook switch, announcement playback, message recording and message playback.

Top module: `ans_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in the idle state with all four enables low and the ring count at zero. After reset with the flag clear, exactly four rings are needed to pick up.
- R2: With `msg_waiting` low, the third ring rise leaves the controller idle. The fourth ring rise sets `hook_off` and `ann_en` on the third clock edge after `ring_in` goes high: two edges for the synchronizer and one for the state register.
- R3: With `msg_waiting` high, the first ring rise after idle picks up, with the same three-edge latency.
- R4: While off hook, ring rises change neither the phase nor the enables.
- R5: `ann_en` stays high until an `ann_end` pulse. On the edge that samples that pulse, `ann_en` drops and `rec_en` rises.
- R6: A `rec_end` pulse during recording drops `rec_en` and `hook_off` on the edge that samples it.
- R7: Without `rec_end`, recording ends by itself after exactly `REC_LIMIT` cycles of `rec_en` high.
- R8: A `tone_det` pulse during the announcement drops `ann_en` and raises `play_en` on the edge that samples it, with the controller still off hook.
- R9: When `tone_det` and `ann_end` arrive in the same cycle during the announcement, the tone wins and the controller enters playback, not recording.
- R10: A `play_end` pulse during playback drops `play_en` and `hook_off` on the edge that samples it.
- R11: Phase inputs outside their own phase are ignored. This covers a tone in idle, `play_end` during recording, and `ann_end` during playback.
- R12: The ring count is cleared at pickup. After a hang-up with the flag clear, the next call again needs four rings.
- R13: At most one of `ann_en`, `rec_en` and `play_en` is high at a time. `hook_off` is high exactly when one of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_in | input | 1 | Ring detector level, asynchronous |
| tone_det | input | 1 | Valid remote-access tone pulse |
| ann_end | input | 1 | End-of-announcement pulse |
| rec_end | input | 1 | End-of-record pulse |
| play_end | input | 1 | End-of-playback pulse |
| msg_waiting | input | 1 | High while an unheard message is stored |
| hook_off | output | 1 | Line pickup enable |
| ann_en | output | 1 | Announcement playback enable |
| rec_en | output | 1 | Message record enable |
| play_en | output | 1 | Message playback enable |

## Verification
The announcement phase has two exits that can fall in the same cycle: the remote-access tone and the end of the announcement. The bench drives `tone_det` and `ann_end` high on the same falling edge during the announcement. It then judges on the next sample that `play_en` is high while `rec_en` and `ann_en` are low. Recording has a similar collision between `rec_end` and the timeout. Both lead to the same hang-up, so only the timeout alone is measured for its exact length.

// File: rtl/ans_ctrl.sv
module ans_ctrl #(
  parameter int RINGS_EMPTY = 4,
  parameter int RINGS_MSG   = 1,
  parameter int REC_LIMIT   = 400000
) (
  input  logic clk,
  input  logic rst,
  input  logic ring_in,
  input  logic tone_det,
  input  logic ann_end,
  input  logic rec_end,
  input  logic play_end,
  input  logic msg_waiting,
  output logic hook_off,
  output logic ann_en,
  output logic rec_en,
  output logic play_en
);
  localparam int RW = $clog2(RINGS_EMPTY + 1);
  localparam int TW = $clog2(REC_LIMIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_ANN, S_REC, S_PLAY} st_t;

  st_t           st, st_nx;
  logic [2:0]    ring_sh;
  logic [RW-1:0] ring_cnt;
  logic [RW-1:0] target;
  logic [RW:0]   cnt_inc;
  logic [TW-1:0] rec_tmr;
  logic          ring_rise, pickup, rec_done;

  assign ring_rise = ring_sh[1] & ~ring_sh[2];
  assign target    = msg_waiting ? RW'(RINGS_MSG) : RW'(RINGS_EMPTY);
  assign cnt_inc   = {1'b0, ring_cnt} + {{RW{1'b0}}, 1'b1};
  assign pickup    = ring_rise && (cnt_inc >= {1'b0, target});
  assign rec_done  = rec_end || (rec_tmr == TW'(REC_LIMIT - 1));

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (pickup) st_nx = S_ANN;
      S_ANN: begin
        if (tone_det)     st_nx = S_PLAY;
        else if (ann_end) st_nx = S_REC;
      end
      S_REC:  if (rec_done) st_nx = S_IDLE;
      S_PLAY: if (play_end) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      ring_sh  <= '0;
      ring_cnt <= '0;
      rec_tmr  <= '0;
    end else begin
      st      <= st_nx;
      ring_sh <= {ring_sh[1:0], ring_in};
      if (st != S_IDLE || pickup) ring_cnt <= '0;
      else if (ring_rise)         ring_cnt <= cnt_inc[RW-1:0];
      if (st == S_REC) rec_tmr <= rec_tmr + 1'b1;
      else             rec_tmr <= '0;
    end
  end

  assign hook_off = (st != S_IDLE);
  assign ann_en   = (st == S_ANN);
  assign rec_en   = (st == S_REC);
  assign play_en  = (st == S_PLAY);
endmodule

// File: rtl/ans_ctrl_chk.sv
module ans_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic tone_det,
  input logic ann_end,
  input logic rec_end,
  input logic play_end,
  input logic hook_off,
  input logic ann_en,
  input logic rec_en,
  input logic play_en
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !hook_off && !ann_en && !rec_en && !play_en); // R1
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst) $onehot0({ann_en, rec_en, play_en})); // R13
  AST_HOOK_MATCH: assert property (@(posedge clk) disable iff (rst) hook_off == (ann_en | rec_en | play_en)); // R13
  AST_ANN_HOLD: assert property (@(posedge clk) disable iff (rst) ann_en && !tone_det && !ann_end |=> ann_en); // R5
  AST_ANN_TO_REC: assert property (@(posedge clk) disable iff (rst) ann_en && ann_end && !tone_det |=> rec_en); // R5
  AST_TONE_PLAY: assert property (@(posedge clk) disable iff (rst) ann_en && tone_det |=> play_en); // R8 R9
  AST_REC_STOP: assert property (@(posedge clk) disable iff (rst) rec_en && rec_end |=> !hook_off); // R6
  AST_PLAY_HOLD: assert property (@(posedge clk) disable iff (rst) play_en && !play_end |=> play_en); // R10
  AST_PLAY_STOP: assert property (@(posedge clk) disable iff (rst) play_en && play_end |=> !hook_off); // R10
endmodule

bind ans_ctrl ans_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .tone_det(tone_det), .ann_end(ann_end),
  .rec_end(rec_end), .play_end(play_end), .hook_off(hook_off),
  .ann_en(ann_en), .rec_en(rec_en), .play_en(play_en)
);

// File: tb/tb_ans_ctrl.sv
module tb_ans_ctrl;
  localparam int LIM = 20;
  logic clk = 1'b0, rst = 1'b1;
  logic ring_in = 0, tone_det = 0, ann_end = 0, rec_end = 0, play_end = 0, msg_waiting = 0;
  logic hook_off, ann_en, rec_en, play_en;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ans_ctrl #(.RINGS_EMPTY(4), .RINGS_MSG(1), .REC_LIMIT(LIM)) dut (.*);

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {hook,ann,rec,play} actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {hook_off, ann_en, rec_en, play_en};
  endfunction

  task automatic ring_pulse();
    @(negedge clk) ring_in = 1;
    repeat (6) @(negedge clk);
    ring_in = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1;
    @(negedge clk) sig = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1 during reset", outs(), 4'b0000);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", outs(), 4'b0000);
  endtask

  task automatic t_four_rings();
    msg_waiting = 0;
    repeat (3) ring_pulse();
    chk("R2 R1 idle after three rings", outs(), 4'b0000);
    @(negedge clk) ring_in = 1;
    @(negedge clk); @(negedge clk);
    chk("R2 not yet at second edge", outs(), 4'b0000);
    @(negedge clk);
    chk("R2 pickup at third edge", outs(), 4'b1100);
    ring_in = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_ring_ignored_then_record_end();
    repeat (3) ring_pulse();
    chk("R4 rings ignored in announce", outs(), 4'b1100);
    repeat (5) @(negedge clk);
    chk("R5 announce held", outs(), 4'b1100);
    pulse(ann_end);
    chk("R5 announce to record", outs(), 4'b1010);
    ring_pulse();
    chk("R4 ring ignored in record", outs(), 4'b1010);
    pulse(play_end);
    chk("R11 play_end ignored in record", outs(), 4'b1010);
    pulse(rec_end);
    chk("R6 record end hangs up", outs(), 4'b0000);
  endtask

  task automatic t_recount();
    msg_waiting = 0;
    repeat (3) ring_pulse();
    chk("R12 count restarted", outs(), 4'b0000);
    ring_pulse();
    chk("R12 fourth ring picks up", outs(), 4'b1100);
  endtask

  task automatic t_timeout();
    @(negedge clk) ann_end = 1;
    @(negedge clk) ann_end = 0;
    chk("R7 record entered", outs(), 4'b1010);
    repeat (LIM - 1) @(negedge clk);
    chk("R7 still recording at limit-1", outs(), 4'b1010);
    @(negedge clk);
    chk("R7 timeout hangs up", outs(), 4'b0000);
  endtask

  task automatic t_msg_tone();
    msg_waiting = 1;
    pulse(tone_det);
    chk("R11 tone ignored in idle", outs(), 4'b0000);
    @(negedge clk) ring_in = 1;
    repeat (2) @(negedge clk);
    chk("R3 not yet", outs(), 4'b0000);
    @(negedge clk);
    chk("R3 first ring pickup", outs(), 4'b1100);
    ring_in = 0;
    repeat (4) @(negedge clk);
    pulse(tone_det);
    chk("R8 tone to playback", outs(), 4'b1001);
    pulse(ann_end);
    chk("R11 ann_end ignored in playback", outs(), 4'b1001);
    ring_pulse();
    chk("R4 ring ignored in playback", outs(), 4'b1001);
    pulse(play_end);
    chk("R10 playback end hangs up", outs(), 4'b0000);
  endtask

  task automatic t_collision();
    msg_waiting = 1;
    ring_pulse();
    chk("R3 pickup before collision", outs(), 4'b1100);
    @(negedge clk) begin tone_det = 1; ann_end = 1; end
    @(negedge clk) begin tone_det = 0; ann_end = 0; end
    chk("R9 tone wins over ann_end", outs(), 4'b1001);
    pulse(play_end);
    chk("R10 hang up after collision", outs(), 4'b0000);
  endtask

  initial begin
    do_reset();
    t_four_rings();
    t_ring_ignored_then_record_end();
    t_recount();
    t_timeout();
    t_msg_tone();
    t_collision();
    do_reset();
    msg_waiting = 0;
    repeat (3) ring_pulse();
    chk("R1 reset needs four rings", outs(), 4'b0000);
    ring_pulse();
    chk("R1 fourth ring after reset", outs(), 4'b1100);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule